// File: doc/BRIEF.md
# Recirculating Sample Window Store

This block takes a burst of received 8-bit samples and holds 240 of them as one window. It then replays the window at the full clock rate, without end, to an adaptation engine. That engine wants one new consecutive sample every 41 cycles. The block meets this rate without dividing the clock.

The storage is viewed as 6 rows of 40 usable columns. A single rotating pointer walks the whole store on every cycle, and each row taps the store at a fixed offset of 40 entries behind the one before it. Because 41 is one more than the row pitch, the sample that comes next in order always lies on the next row, 41 cycles later. A row select therefore steps by one row per period and feeds one output multiplexer. When a window ends early, the unfilled entries are written as zero. When a new capture is requested during replay, the block waits until a complete pass has been delivered, so the engine never sees a window that is only partly replaced.

Top module: `loop_window_store`

## Requirements
- R1: During reset and right after it, `dout_stb` is 0 and `dout` is 0, and no strobe appears until a capture has completed.
- R2: A `cap_start` pulse, when the block is not replaying, starts acquisition. Each cycle with `win_valid` high then stores `din` as the next sample of the window, in arrival order.
- R3: Once 240 samples are stored, replay begins. `dout_stb` then pulses high for exactly one cycle every 41 cycles.
- R4: Successive strobes deliver the stored samples in capture order (sample 0 first), and the sequence repeats with a period of 240 strobes.
- R5: If `win_valid` falls after at least one sample and before 240 are stored, the remaining entries are filled with 0 (one per cycle) and then replay begins. Those entries are delivered as 0.
- R6: A `cap_start` that arrives during replay is held until the pass in progress has delivered its last sample (index 239). Acquisition then restarts, and no strobe occurs until the new window is full.
- R7: `win_valid` and `din` have no effect on the delivered samples during replay.
- R8: `dout_stb` stays low for the whole time the block is acquiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_start | input | 1 | Request to capture a new window |
| win_valid | input | 1 | High while `din` carries a window sample |
| din | input | 8 | Received sample |
| dout | output | 8 | Sample delivered to the adaptation engine |
| dout_stb | output | 1 | One-cycle strobe marking a new `dout` |

## Verification
A full window of distinct values is replayed for two passes. This shows that the row select really walks through consecutive samples and wraps at 240, rather than repeating a row or skipping a column. A short window of 100 samples tells zero padding apart from stale contents. A capture request issued in the middle of a pass, together with junk on `win_valid`, separates deferred capture from immediate capture and from writes during replay. Strobe spacing is measured on every pass.

// File: rtl/loop_window_store.sv
module loop_window_store #(
  parameter int W    = 8,
  parameter int ROWS = 6,
  parameter int COLS = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_start,
  input  logic         win_valid,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_stb
);
  localparam int DEPTH  = ROWS * COLS;
  localparam int PERIOD = COLS + 1;
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = $clog2(PERIOD);
  localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1;

  typedef enum logic [1:0] {IDLE, ACQ, LOOP} st_t;

  st_t           state;
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [CW-1:0] cnt;
  logic [RW-1:0] row;
  logic          seen, pad, pend;
  logic [W-1:0]  tap  [ROWS];
  logic [AW-1:0] taddr [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AW:0] raw;
    assign raw      = {1'b0, ptr} + (AW+1)'(DEPTH - r * COLS);
    assign taddr[r] = (raw >= (AW+1)'(DEPTH)) ? AW'(raw - (AW+1)'(DEPTH)) : raw[AW-1:0];
    assign tap[r]   = mem[taddr[r]];
  end

  logic looping, pad_now, wr, at_start, req, last;
  logic [W-1:0] wdata;

  assign looping  = (state == LOOP);
  assign pad_now  = pad | (seen & ~win_valid);
  assign wr       = (state == ACQ) & ~cap_start & (win_valid | pad_now);
  assign wdata    = pad_now ? '0 : din;
  assign at_start = (cnt == '0) && (taddr[row] == '0);
  assign req      = pend | cap_start;
  assign last     = (ptr == AW'(DEPTH - 1));

  always_ff @(posedge clk)
    if (wr) mem[ptr] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      ptr      <= '0;
      cnt      <= '0;
      row      <= '0;
      seen     <= 1'b0;
      pad      <= 1'b0;
      pend     <= 1'b0;
      dout     <= '0;
      dout_stb <= 1'b0;
    end else begin
      dout_stb <= 1'b0;
      case (state)
        IDLE: if (cap_start) begin
          state <= ACQ;
          ptr   <= '0;
          seen  <= 1'b0;
          pad   <= 1'b0;
        end
        ACQ: if (cap_start) begin
          ptr  <= '0;
          seen <= 1'b0;
          pad  <= 1'b0;
        end else if (wr) begin
          seen <= seen | win_valid;
          pad  <= pad_now;
          if (last) begin
            state <= LOOP;
            ptr   <= '0;
            cnt   <= '0;
            row   <= '0;
            pend  <= 1'b0;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        LOOP: begin
          ptr  <= last ? '0 : ptr + 1'b1;
          cnt  <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
          if (cnt == CW'(PERIOD - 1))
            row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
          pend <= req;
          if (cnt == '0) begin
            if (at_start && req) begin
              state <= ACQ;
              ptr   <= '0;
              seen  <= 1'b0;
              pad   <= 1'b0;
              pend  <= 1'b0;
            end else begin
              dout_stb <= 1'b1;
              dout     <= tap[row];
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/loop_window_store_chk.sv
module loop_window_store_chk #(
  parameter int PERIOD = 41
) (
  input logic clk,
  input logic rst_n,
  input logic dout_stb,
  input logic looping
);
  logic [15:0] gap;
  logic        had_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '0;
      had_stb <= 1'b0;
    end else if (dout_stb) begin
      gap     <= '0;
      had_stb <= 1'b1;
    end else if (gap != 16'hffff) begin
      gap <= gap + 1'b1;
    end
  end

  p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_stb |=> !dout_stb);

  p_stb_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_stb && had_stb) |-> (gap >= 16'(PERIOD - 2)));

  p_stb_only_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_stb |-> $past(looping));

  p_exit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(looping) |-> !dout_stb);

  p_entry_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(looping) |-> !dout_stb);
endmodule

bind loop_window_store loop_window_store_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dout_stb(dout_stb), .looping(looping)
);

// File: tb/loop_window_store_test.sv
module loop_window_store_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 240;
  localparam int GAP = 41;

  logic clk = 1'b0, rst_n = 1'b0, cap_start = 1'b0, win_valid = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_stb;

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  int gap = 0;
  bit gap_ok = 0;
  bit prev_stb = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_window_store uut (
    .clk(clk), .rst_n(rst_n), .cap_start(cap_start), .win_valid(win_valid),
    .din(din), .dout(dout), .dout_stb(dout_stb)
  );

  function automatic int val_a(int i); return (i * 7 + 3) % 256; endfunction
  function automatic int val_b(int i); return (i * 13 + 1) % 255 + 1; endfunction
  function automatic int val_c(int i); return (255 - i) % 256; endfunction

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    cyc++;
    gap++;
    if (dout_stb) begin
      checks++;
      if (prev_stb) begin
        errors++;
        $display("FAIL R3 strobe wider than one cycle: got 2 expected 1");
      end
      if (gap_ok && gap != GAP) begin
        errors++;
        $display("FAIL R3 strobe spacing: got %0d expected %0d", gap, GAP);
      end
      gap = 0;
      gap_ok = 1;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8/R6 unexpected strobe: got 1 expected 0 (dout=%0h)", dout);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (dout !== 8'(e)) begin
          errors++;
          $display("FAIL %s sample: got %0h expected %0h", t, dout, e);
        end
      end
    end
    prev_stb = dout_stb;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    cap_start = 1'b0;
    win_valid = 1'b0;
    repeat (3) @(negedge clk);
    gap_ok = 0;
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dout_stb !== 1'b0 || dout !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset state: got stb=%b dout=%0h expected stb=0 dout=0", dout_stb, dout);
    end
  endtask

  // sel: 0 = A, 1 = B, 2 = C
  function automatic int pick(int sel, int i);
    if (sel == 0) return val_a(i);
    if (sel == 1) return val_b(i);
    return val_c(i);
  endfunction

  task automatic push_pass(int sel, int n, string t);
    for (int i = 0; i < DEPTH; i++) begin
      exp_q.push_back(i < n ? pick(sel, i) : 0);
      tag_q.push_back(i < n ? t : "R5");
    end
  endtask

  task automatic send_window(int sel, int n, bit pulse);
    if (pulse) begin
      @(negedge clk); cap_start = 1'b1;
      @(negedge clk); cap_start = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      win_valid = 1'b1;
      din = 8'(pick(sel, i));
      @(negedge clk);
    end
    win_valid = 1'b0;
    din = 8'h00;
  endtask

  task automatic wait_queue(int level);
    while (exp_q.size() > level) @(negedge clk);
  endtask

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();                       // R1
    repeat (60) @(negedge clk);
    checks++;                         // R1: nothing before capture
    if (exp_q.size() != 0) errors++;

    // R2 R3 R4 R8: full window, two passes
    push_pass(0, DEPTH, "R4");
    push_pass(0, DEPTH, "R4");
    send_window(0, DEPTH, 1'b1);
    wait_queue(0);

    do_reset();
    // R5: short window, padded with zeros
    push_pass(1, 100, "R2");
    send_window(1, 100, 1'b1);
    wait_queue(0);

    do_reset();
    // R6 R7: capture requested mid-pass, junk during replay
    push_pass(0, DEPTH, "R4");
    push_pass(0, DEPTH, "R6");
    send_window(0, DEPTH, 1'b1);
    wait_queue(DEPTH - 50);
    @(negedge clk); cap_start = 1'b1;
    @(negedge clk); cap_start = 1'b0;
    for (int i = 0; i < 30; i++) begin   // R7: must be ignored
      win_valid = 1'b1;
      din = 8'(i * 3);
      @(negedge clk);
    end
    win_valid = 1'b0;
    wait_queue(0);
    repeat (45) @(negedge clk);
    gap_ok = 0;
    push_pass(2, DEPTH, "R6");
    send_window(2, DEPTH, 1'b0);
    wait_queue(0);
    repeat (5) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule